// File: doc/BRIEF.md
# Lockable Translation Lookaside Buffer with Victim Pointer

This block is a small fully associative translation cache for a processor's address translation unit. Each slot holds a virtual tag, a physical base, a flag saying whether the slot maps a whole 1 MB section or a single 4 KB page, a valid bit and a lock bit. The lookup port compares every slot's tag against the incoming virtual address in the same cycle. It answers with a hit and the translated physical address, or with a miss.

Slots are written in one of two ways. While the hardware table walker is enabled, the walker delivers each finished translation through the fill port. The fill lands in the slot chosen by a replacement pointer, and that pointer then moves on to the next slot that is not locked. While the walker is disabled, host software owns the cache. It loads slots by index, sets or clears lock bits and writes the walk-table base. A lookup miss in this mode raises an interrupt request and records the missing address. A global invalidate drops every unlocked slot and keeps the locked ones.

Top module: `ltlb_top`

## Requirements
- R1: A lookup with `q_valid` high gives `q_hit` or `q_miss` in the same cycle, never both. A page slot matches when its tag equals `q_va[23:12]`, and a section slot matches when its tag bits [11:8] equal `q_va[23:20]`. On a hit, `q_pa` is `{pbase, q_va[11:0]}` for a page and `{pbase[11:8], q_va[19:0]}` for a section.
- R2: When several valid slots match, the slot with the lowest index supplies `q_pa`.
- R3: A fill writes the slot shown on `victim_idx` as valid and unlocked. `victim_idx` then moves to the next unlocked slot in increasing index order, wrapping from the last slot to slot 0.
- R4: `victim_idx` never names a locked slot while at least one slot is unlocked, so a fill never overwrites a locked slot.
- R5: If every slot is locked, a fill changes no slot and `victim_idx` stays where it is. `fill_drop` goes high on the next cycle and stays high until `stat_ack`.
- R6: While `walk_en` is high, manual slot loads, lock writes and table-base writes have no effect. While it is low, they take effect on the next cycle.
- R7: While `walk_en` is low, a lookup miss sets `irq_miss` on the next cycle and latches the missing address on `miss_va`. Both hold until `stat_ack`, and a later miss does not overwrite `miss_va`.
- R8: While `walk_en` is high, a lookup miss does not raise `irq_miss`.
- R9: `inval_all` clears the valid bit of every unlocked slot. Locked slots stay valid and keep translating.
- R10: After reset, all slots are invalid and unlocked, `victim_idx` is 0, and `irq_miss`, `fill_drop` and `tbase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_en | input | 1 | Hardware table walker enabled |
| q_valid | input | 1 | Lookup request |
| q_va | input | 24 | Lookup virtual address |
| q_hit | output | 1 | Lookup hit |
| q_miss | output | 1 | Lookup miss |
| q_pa | output | 24 | Translated physical address |
| fill_valid | input | 1 | Walker fill strobe |
| fill_vtag | input | 12 | Fill virtual tag, address bits [23:12] |
| fill_pbase | input | 12 | Fill physical base, address bits [23:12] |
| fill_sect | input | 1 | Fill maps a section (1) or a page (0) |
| ld_wr | input | 1 | Manual slot load strobe |
| ld_idx | input | 3 | Manual load slot index |
| ld_vtag | input | 12 | Manual load virtual tag |
| ld_pbase | input | 12 | Manual load physical base |
| ld_sect | input | 1 | Manual load section flag |
| ld_lock | input | 1 | Manual load lock bit |
| lock_wr | input | 1 | Lock write strobe |
| lock_idx | input | 3 | Lock write slot index |
| lock_set | input | 1 | New lock value |
| tbase_wr | input | 1 | Walk-table base write strobe |
| tbase_in | input | 24 | New walk-table base |
| tbase | output | 24 | Walk-table base register |
| inval_all | input | 1 | Global invalidate of unlocked slots |
| stat_ack | input | 1 | Clears `irq_miss` and `fill_drop` |
| irq_miss | output | 1 | Miss interrupt request |
| miss_va | output | 24 | Latched missing virtual address |
| fill_drop | output | 1 | A fill was dropped because every slot was locked |
| victim_idx | output | 3 | Slot the next fill will write |

## Verification
The replacement-pointer properties take for granted that lock bits do not change in the same cycle as a fill. Locks can only be written with the walker off and fills come from the walker, so the stimulus always changes walker mode before switching between lock writes and fills. The locked-slot retention check applies only in cycles with no manual load or lock write, which is how the bench drives invalidates. The stimulus issues one operation per cycle and never sends an acknowledge in the same cycle as a miss.

// File: rtl/ltlb_pkg.sv
package ltlb_pkg;
   localparam int LTLB_ENTRIES   = 8;
   localparam int LTLB_VA_W      = 24;
   localparam int LTLB_PA_W      = 24;
   localparam int LTLB_PG_SHIFT  = 12;
   localparam int LTLB_SEC_SHIFT = 20;

   typedef enum logic {
      KIND_PAGE = 1'b0,
      KIND_SECT = 1'b1
   } ltlb_kind_e;
endpackage

// File: rtl/ltlb_match.sv
module ltlb_match #(
   parameter int N     = 8,
   parameter int TG_W  = 12,
   parameter int SEC_W = 4
) (
   input  logic [N-1:0]    ent_valid,
   input  logic [N-1:0]    ent_sect,
   input  logic [TG_W-1:0] ent_tag [N],
   input  logic [TG_W-1:0] q_tag,
   output logic [N-1:0]    match_vec
);
   initial begin
      assert (SEC_W > 0 && SEC_W <= TG_W)
         else $error("ltlb_match: section width must lie within the tag");
   end

   for (genvar g = 0; g < N; g++) begin : g_ent
      logic hi_eq;
      logic lo_eq;
      assign hi_eq = ent_tag[g][TG_W-1 -: SEC_W] == q_tag[TG_W-1 -: SEC_W];
      if (SEC_W == TG_W) begin : g_flat
         assign lo_eq = 1'b1;
      end else begin : g_split
         assign lo_eq = ent_tag[g][TG_W-SEC_W-1:0] == q_tag[TG_W-SEC_W-1:0];
      end
      assign match_vec[g] = ent_valid[g] & hi_eq &
                            (ent_sect[g] == ltlb_pkg::KIND_SECT | lo_eq);
   end
endmodule

// File: rtl/ltlb_pick.sv
module ltlb_pick #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/ltlb_victim.sv
module ltlb_victim #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  lock_vec,
   input  logic          adv,
   output logic [IW-1:0] tgt_idx,
   output logic          tgt_ok
);
   initial begin
      assert (N >= 2 && (N & (N - 1)) == 0)
         else $error("ltlb_victim: slot count must be a power of two, at least 2");
   end

   logic [IW-1:0] ptr_q;
   logic [IW:0]   cur_scan;
   logic [IW:0]   nxt_scan;

   function automatic logic [IW:0] first_free(input logic [IW-1:0] start,
                                              input logic [N-1:0]  lk);
      logic [IW:0]   r;
      logic [IW-1:0] j;
      r = '0;
      for (int k = N - 1; k >= 0; k--) begin
         j = start + IW'(k);
         if (!lk[j]) r = {1'b1, j};
      end
      return r;
   endfunction

   always_comb begin
      cur_scan = first_free(ptr_q, lock_vec);
      nxt_scan = first_free(cur_scan[IW-1:0] + IW'(1), lock_vec);
   end

   assign tgt_ok  = cur_scan[IW];
   assign tgt_idx = tgt_ok ? cur_scan[IW-1:0] : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv && tgt_ok)
         ptr_q <= nxt_scan[IW-1:0];
   end

   // R5: with every slot locked the pointer does not move
   p_drop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (&lock_vec)) |=> ptr_q == $past(ptr_q));

   // R3: with more than one free slot the pointer leaves the slot just filled
   p_moves_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && tgt_ok && $countones(~lock_vec) > 1) |=> ptr_q != $past(tgt_idx));
endmodule

// File: rtl/ltlb_top.sv
module ltlb_top #(
   parameter int N_ENT  = ltlb_pkg::LTLB_ENTRIES,
   parameter int VA_W   = ltlb_pkg::LTLB_VA_W,
   parameter int PA_W   = ltlb_pkg::LTLB_PA_W,
   parameter int PG_SH  = ltlb_pkg::LTLB_PG_SHIFT,
   parameter int SEC_SH = ltlb_pkg::LTLB_SEC_SHIFT,
   localparam int IW    = $clog2(N_ENT),
   localparam int TG_W  = VA_W - PG_SH,
   localparam int PB_W  = PA_W - PG_SH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            walk_en,
   input  logic            q_valid,
   input  logic [VA_W-1:0] q_va,
   output logic            q_hit,
   output logic            q_miss,
   output logic [PA_W-1:0] q_pa,
   input  logic            fill_valid,
   input  logic [TG_W-1:0] fill_vtag,
   input  logic [PB_W-1:0] fill_pbase,
   input  logic            fill_sect,
   input  logic            ld_wr,
   input  logic [IW-1:0]   ld_idx,
   input  logic [TG_W-1:0] ld_vtag,
   input  logic [PB_W-1:0] ld_pbase,
   input  logic            ld_sect,
   input  logic            ld_lock,
   input  logic            lock_wr,
   input  logic [IW-1:0]   lock_idx,
   input  logic            lock_set,
   input  logic            tbase_wr,
   input  logic [PA_W-1:0] tbase_in,
   output logic [PA_W-1:0] tbase,
   input  logic            inval_all,
   input  logic            stat_ack,
   output logic            irq_miss,
   output logic [VA_W-1:0] miss_va,
   output logic            fill_drop,
   output logic [IW-1:0]   victim_idx
);
   localparam int SEC_W  = VA_W - SEC_SH;
   localparam int SPB_W  = PA_W - SEC_SH;

   initial begin
      assert (PG_SH > 0 && SEC_SH > PG_SH && SEC_SH < VA_W && SEC_SH < PA_W)
         else $error("ltlb_top: shifts must satisfy 0 < page < section < width");
   end

   logic [N_ENT-1:0] valid_q, lock_q, sect_q;
   logic [TG_W-1:0]  tag_q [N_ENT];
   logic [PB_W-1:0]  pb_q  [N_ENT];
   logic [PA_W-1:0]  tbase_q;
   logic             irq_q, drop_q;
   logic [VA_W-1:0]  mva_q;

   logic [N_ENT-1:0] match_vec;
   logic             any_hit;
   logic [IW-1:0]    sel_idx;
   logic [IW-1:0]    tgt_idx;
   logic             tgt_ok;
   logic             man_ok, fill_fire, miss_ev;

   ltlb_match #(.N(N_ENT), .TG_W(TG_W), .SEC_W(SEC_W)) u_match (
      .ent_valid (valid_q),
      .ent_sect  (sect_q),
      .ent_tag   (tag_q),
      .q_tag     (q_va[VA_W-1:PG_SH]),
      .match_vec (match_vec)
   );

   ltlb_pick #(.N(N_ENT), .IW(IW)) u_pick (
      .req (match_vec),
      .any (any_hit),
      .idx (sel_idx)
   );

   ltlb_victim #(.N(N_ENT), .IW(IW)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_vec (lock_q),
      .adv      (fill_valid),
      .tgt_idx  (tgt_idx),
      .tgt_ok   (tgt_ok)
   );

   assign man_ok    = !walk_en;
   assign fill_fire = fill_valid && tgt_ok;
   assign miss_ev   = q_valid && !any_hit && !walk_en;

   assign q_hit  = q_valid && any_hit;
   assign q_miss = q_valid && !any_hit;
   always_comb begin
      if (sect_q[sel_idx] == ltlb_pkg::KIND_SECT)
         q_pa = {pb_q[sel_idx][PB_W-1 -: SPB_W], q_va[SEC_SH-1:0]};
      else
         q_pa = {pb_q[sel_idx], q_va[PG_SH-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         lock_q  <= '0;
         sect_q  <= '0;
         for (int i = 0; i < N_ENT; i++) begin
            tag_q[i] <= '0;
            pb_q[i]  <= '0;
         end
      end else begin
         if (inval_all)
            valid_q <= valid_q & lock_q;
         if (man_ok && ld_wr) begin
            valid_q[ld_idx] <= 1'b1;
            lock_q[ld_idx]  <= ld_lock;
            sect_q[ld_idx]  <= ld_sect;
            tag_q[ld_idx]   <= ld_vtag;
            pb_q[ld_idx]    <= ld_pbase;
         end
         if (man_ok && lock_wr)
            lock_q[lock_idx] <= lock_set;
         if (fill_fire) begin
            valid_q[tgt_idx] <= 1'b1;
            lock_q[tgt_idx]  <= 1'b0;
            sect_q[tgt_idx]  <= fill_sect;
            tag_q[tgt_idx]   <= fill_vtag;
            pb_q[tgt_idx]    <= fill_pbase;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbase_q <= '0;
         irq_q   <= 1'b0;
         mva_q   <= '0;
         drop_q  <= 1'b0;
      end else begin
         if (man_ok && tbase_wr)
            tbase_q <= tbase_in;
         if (stat_ack) begin
            irq_q  <= 1'b0;
            drop_q <= 1'b0;
         end
         if (miss_ev && (!irq_q || stat_ack)) begin
            irq_q <= 1'b1;
            mva_q <= q_va;
         end
         if (fill_valid && !tgt_ok)
            drop_q <= 1'b1;
      end
   end

   assign tbase      = tbase_q;
   assign irq_miss   = irq_q;
   assign miss_va    = mva_q;
   assign fill_drop  = drop_q;
   assign victim_idx = tgt_idx;

   // R1: hit and miss are exclusive
   p_hit_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_hit && q_miss));

   // R7: pending interrupt and its address persist until acknowledged
   p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_miss && !stat_ack) |=> (irq_miss && $stable(miss_va)));

   // R8: no interrupt appears without a miss in walker-off mode
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_miss && (walk_en || !q_valid)) |=> !irq_miss);

   // R6: table base is frozen while the walker runs
   p_tbase_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      walk_en |=> tbase == $past(tbase));

   // R5: fill against a fully locked cache raises the drop flag
   p_drop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && (&lock_q)) |=> fill_drop);

   // R9: invalidate keeps locked valid slots
   p_locked_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_all && !ld_wr && !lock_wr) |=>
         ((valid_q & $past(valid_q & lock_q)) == $past(valid_q & lock_q)));
endmodule

// File: tb/ltlb_top_test.sv
`timescale 1ns/1ps
module ltlb_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_en = 1'b0;
   logic        q_valid = 1'b0;
   logic [23:0] q_va = '0;
   logic        q_hit, q_miss;
   logic [23:0] q_pa;
   logic        fill_valid = 1'b0;
   logic [11:0] fill_vtag = '0, fill_pbase = '0;
   logic        fill_sect = 1'b0;
   logic        ld_wr = 1'b0;
   logic [2:0]  ld_idx = '0;
   logic [11:0] ld_vtag = '0, ld_pbase = '0;
   logic        ld_sect = 1'b0, ld_lock = 1'b0;
   logic        lock_wr = 1'b0;
   logic [2:0]  lock_idx = '0;
   logic        lock_set = 1'b0;
   logic        tbase_wr = 1'b0;
   logic [23:0] tbase_in = '0;
   logic [23:0] tbase;
   logic        inval_all = 1'b0;
   logic        stat_ack = 1'b0;
   logic        irq_miss;
   logic [23:0] miss_va;
   logic        fill_drop;
   logic [2:0]  victim_idx;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model
   bit          m_valid [8];
   bit          m_lock  [8];
   bit          m_sect  [8];
   logic [11:0] m_tag   [8];
   logic [11:0] m_pb    [8];
   int          m_ptr = 0;
   bit          m_irq = 0, m_drop = 0, m_walk = 0;
   logic [23:0] m_mva = '0, m_tbase = '0;

   always #2 clk = ~clk;

   ltlb_top uut (
      .clk(clk), .rst_n(rst_n), .walk_en(walk_en),
      .q_valid(q_valid), .q_va(q_va), .q_hit(q_hit), .q_miss(q_miss), .q_pa(q_pa),
      .fill_valid(fill_valid), .fill_vtag(fill_vtag), .fill_pbase(fill_pbase),
      .fill_sect(fill_sect),
      .ld_wr(ld_wr), .ld_idx(ld_idx), .ld_vtag(ld_vtag), .ld_pbase(ld_pbase),
      .ld_sect(ld_sect), .ld_lock(ld_lock),
      .lock_wr(lock_wr), .lock_idx(lock_idx), .lock_set(lock_set),
      .tbase_wr(tbase_wr), .tbase_in(tbase_in), .tbase(tbase),
      .inval_all(inval_all), .stat_ack(stat_ack),
      .irq_miss(irq_miss), .miss_va(miss_va), .fill_drop(fill_drop),
      .victim_idx(victim_idx)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int scan(input int start);
      for (int k = 0; k < 8; k++) begin
         if (!m_lock[(start + k) % 8]) return (start + k) % 8;
      end
      return -1;
   endfunction

   function automatic int exp_victim();
      int s;
      s = scan(m_ptr);
      return (s < 0) ? m_ptr : s;
   endfunction

   task automatic chk_state(input string req);
      @(negedge clk);
      chk(victim_idx == 3'(exp_victim()), {req, " victim"}, 32'(victim_idx), 32'(exp_victim()));
      chk(irq_miss == m_irq, {req, " irq"}, 32'(irq_miss), 32'(m_irq));
      if (m_irq) chk(miss_va == m_mva, {req, " miss_va"}, 32'(miss_va), 32'(m_mva));
      chk(fill_drop == m_drop, {req, " drop"}, 32'(fill_drop), 32'(m_drop));
      chk(tbase == m_tbase, {req, " tbase"}, 32'(tbase), 32'(m_tbase));
   endtask

   task automatic look(input logic [23:0] va, input string req);
      bit          h;
      logic [23:0] pa;
      h = 0;
      pa = '0;
      for (int i = 7; i >= 0; i--) begin
         if (m_valid[i] && (m_sect[i] ? (m_tag[i][11:8] == va[23:20])
                                      : (m_tag[i] == va[23:12]))) begin
            h = 1;
            pa = m_sect[i] ? {m_pb[i][11:8], va[19:0]} : {m_pb[i], va[11:0]};
         end
      end
      @(negedge clk);
      q_valid = 1'b1;
      q_va = va;
      #1;
      chk(q_hit == h && q_miss == !h, {req, " hit"}, {30'd0, q_hit, q_miss}, {30'd0, h, !h});
      if (h) chk(q_pa == pa, {req, " pa"}, 32'(q_pa), 32'(pa));
      @(posedge clk);
      #1;
      q_valid = 1'b0;
      if (!m_walk && !h && !m_irq) begin
         m_irq = 1;
         m_mva = va;
      end
   endtask

   task automatic set_walk(input bit w);
      @(negedge clk);
      walk_en = w;
      m_walk = w;
   endtask

   task automatic do_load(input int i, input logic [11:0] t, input logic [11:0] pb,
                          input bit s, input bit lk);
      @(negedge clk);
      ld_wr = 1; ld_idx = 3'(i); ld_vtag = t; ld_pbase = pb; ld_sect = s; ld_lock = lk;
      @(posedge clk);
      #1;
      ld_wr = 0;
      if (!m_walk) begin
         m_valid[i] = 1; m_lock[i] = lk; m_sect[i] = s; m_tag[i] = t; m_pb[i] = pb;
      end
   endtask

   task automatic do_lock(input int i, input bit v);
      @(negedge clk);
      lock_wr = 1; lock_idx = 3'(i); lock_set = v;
      @(posedge clk);
      #1;
      lock_wr = 0;
      if (!m_walk) m_lock[i] = v;
   endtask

   task automatic do_tbase(input logic [23:0] v);
      @(negedge clk);
      tbase_wr = 1; tbase_in = v;
      @(posedge clk);
      #1;
      tbase_wr = 0;
      if (!m_walk) m_tbase = v;
   endtask

   task automatic do_fill(input logic [11:0] t, input logic [11:0] pb, input bit s);
      int tg;
      @(negedge clk);
      fill_valid = 1; fill_vtag = t; fill_pbase = pb; fill_sect = s;
      @(posedge clk);
      #1;
      fill_valid = 0;
      tg = scan(m_ptr);
      if (tg < 0) m_drop = 1;
      else begin
         m_valid[tg] = 1; m_lock[tg] = 0; m_sect[tg] = s; m_tag[tg] = t; m_pb[tg] = pb;
         m_ptr = scan((tg + 1) % 8);
      end
   endtask

   task automatic do_inval();
      @(negedge clk);
      inval_all = 1;
      @(posedge clk);
      #1;
      inval_all = 0;
      for (int i = 0; i < 8; i++) if (!m_lock[i]) m_valid[i] = 0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      stat_ack = 1;
      @(posedge clk);
      #1;
      stat_ack = 0;
      m_irq = 0;
      m_drop = 0;
   endtask

   task automatic sweep(input string req);
      for (int t = 0; t < 4096; t++) look({12'(t), 12'(t * 37)}, req);
   endtask

   initial begin
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      if (!done) begin
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_valid[i] = 0; m_lock[i] = 0; m_sect[i] = 0; m_tag[i] = '0; m_pb[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: reset state
      chk_state("R10");
      look(24'h123456, "R10");
      do_ack();

      // R1: manual page loads, full tag sweep
      for (int i = 0; i < 8; i++)
         do_load(i, 12'(12'h100 + i * 12'h123), 12'(12'hA00 + i), 1'b0, 1'b0);
      sweep("R1");
      do_ack();
      chk_state("R7");

      // R2: section slot overlapping a page slot with lower index
      do_load(6, 12'h300, 12'hC00, 1'b1, 1'b0);
      for (int t = 12'h300; t < 12'h400; t++) look({12'(t), 12'(t * 53)}, "R2");
      do_ack();

      // R7: miss interrupt and latched address
      look(24'hEEE123, "R7");
      chk_state("R7");
      look(24'hDDD000, "R7");
      chk_state("R7");
      do_ack();
      chk_state("R7");

      // R3 / R4: locked slots skipped by the replacement pointer
      do_lock(1, 1'b1);
      do_lock(3, 1'b1);
      set_walk(1'b1);
      chk_state("R4");
      for (int k = 0; k < 12; k++) begin
         do_fill(12'(12'hE00 + k), 12'(12'h500 + k), 1'b0);
         chk_state("R3");
      end
      sweep("R4");

      // R6 / R8: manual access ignored, no interrupt while walking
      do_load(0, 12'hFFF, 12'h777, 1'b0, 1'b1);
      do_lock(2, 1'b1);
      do_tbase(24'h123456);
      chk_state("R6");
      look(24'hFFF000, "R6");
      chk_state("R8");

      // R9: invalidate keeps locked slots
      do_inval();
      sweep("R9");

      // R5: all slots locked
      set_walk(1'b0);
      for (int i = 0; i < 8; i++) do_lock(i, 1'b1);
      do_ack();
      set_walk(1'b1);
      do_fill(12'hABC, 12'h111, 1'b0);
      chk_state("R5");
      look(24'hABC000, "R5");
      do_ack();
      chk_state("R5");

      // R6: manual access works with the walker off
      set_walk(1'b0);
      do_tbase(24'h5A5A5A);
      chk_state("R6");
      do_lock(4, 1'b0);
      do_load(4, 12'h4AB, 12'h0F0, 1'b0, 1'b0);
      look(24'h4AB321, "R6");
      chk_state("R6");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule